// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Receiver

This block is a slave on a two-wire serial bus, in the I2C style, that only accepts writes. It samples the bus clock and data lines with the system clock. It finds START and STOP conditions and the bit boundaries. It checks the address byte and acknowledges each accepted byte by pulling the data line low. The data bytes of the frame are written into a bank of configuration registers. Elsewhere on the chip these registers drive output disables, frequency selection, spread-spectrum enable and output three-state.

A frame is fixed in shape. It starts with the address byte. A command byte and a byte-count byte follow; both must be present, but their values play no part. After them come the data bytes, and each one lands in the register that matches its position in the frame. The registers come out of reset with parameterised default values, so a system that never writes them still runs. A data byte is committed as soon as its eighth bit arrives, so a frame that is cut short keeps what it already delivered.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, `cfg_o` equals the `CFG_INIT` parameter (data byte n at bits [8n+7:8n]), and `sda_oe_o` is 0.
- R2: The address byte 0xD2 (MSB first, write bit 0 included) is acknowledged: `sda_oe_o` is 1 while the bus clock is high in the ninth clock of that byte. Any other value, 0xD3 included, is not acknowledged, and neither is any later byte of that frame.
- R3: A frame whose address does not match leaves every register unchanged.
- R4: In a matched frame, the fourth to eleventh bytes are written to data registers 0 to 7 in that order. A register changes only while the bus clock is high.
- R5: The second and third bytes are acknowledged, and their values have no effect on any register.
- R6: Each data byte is committed as soon as its eighth bit is received. A frame ended by STOP after k data bytes updates registers 0 to k-1 and keeps the others.
- R7: Bytes after the eighth data byte are acknowledged and discarded; no register changes.
- R8: `ss_mode_o` always equals bits [1:0] of data register 0.
- R9: A repeated START, which is a falling data line while the bus clock is high in the middle of a frame, restarts the frame at the address byte.
- R10: A STOP, which is a rising data line while the bus clock is high, ends the frame. A byte that is only partly received when the STOP arrives is dropped.
- R11: `sda_oe_o` changes only while the bus clock is low, and it is 1 only during acknowledge slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| cfg_o | output | NUM_DATA*8 | Configuration register bank, data byte n at [8n+7:8n] |
| ss_mode_o | output | 2 | Spread-spectrum control field, bits [1:0] of data byte 0 |

## Verification
The bench keeps the default address, eight data registers, two header bytes and two synchronizer stages. This is the full eleven-byte frame and the case that sits past its end. The bench overrides `CFG_INIT` with a value that is different in every byte. A byte written to the wrong register, or a register changed when it should not be, then always shows up as a mismatch. A bus quarter-period of six system clocks gives the synchronizer room to work, and the acknowledge window can then be sampled in the middle of the high phase.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK_WAIT,
    ST_ACK_DRV,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_sync[SYNC_STAGES-1];
      sda_q    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_s      = scl_sync[SYNC_STAGES-1];
  assign sda_s      = sda_sync[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edges while clock stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import cfg_rx_pkg::*;
#(
  parameter logic [7:0] SLAVE_ADDR = 8'hD2,
  parameter int NUM_DATA  = 8,
  parameter int HDR_BYTES = 2,
  parameter int IDX_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);
  localparam int FIRST_DATA = HDR_BYTES + 1;
  localparam int LAST_DATA  = HDR_BYTES + NUM_DATA;
  localparam int OVER_IDX   = LAST_DATA + 1;

  rx_state_e        state_q;
  logic [2:0]       bit_cnt_q;
  logic [6:0]       shreg_q;
  logic [IDX_W-1:0] byte_idx_q;
  logic [7:0]       byte_full;
  logic             last_bit;

  assign byte_full = {shreg_q, sda_i};
  assign last_bit  = (state_q == ST_RECV) && scl_rise_i && (bit_cnt_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      byte_idx_q <= '0;
      sda_oe_o   <= 1'b0;
    end else if (start_i) begin
      state_q    <= ST_RECV;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      sda_oe_o   <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RECV: if (scl_rise_i) begin
          shreg_q   <= byte_full[6:0];
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            if (byte_idx_q == '0 && byte_full != SLAVE_ADDR) state_q <= ST_SKIP;
            else state_q <= ST_ACK_WAIT;
            if (byte_idx_q != IDX_W'(OVER_IDX)) byte_idx_q <= byte_idx_q + 1'b1;
          end
        end
        ST_ACK_WAIT: if (scl_fall_i) begin
          sda_oe_o <= 1'b1;
          state_q  <= ST_ACK_DRV;
        end
        ST_ACK_DRV: if (scl_fall_i) begin
          sda_oe_o  <= 1'b0;
          bit_cnt_q <= '0;
          state_q   <= ST_RECV;
        end
        default: ;
      endcase
    end
  end

  assign wr_en_o   = last_bit && (byte_idx_q >= IDX_W'(FIRST_DATA))
                              && (byte_idx_q <= IDX_W'(LAST_DATA));
  assign wr_idx_o  = byte_idx_q - IDX_W'(FIRST_DATA);
  assign wr_data_o = byte_full;
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
  parameter int NUM_DATA = 8,
  parameter int IDX_W    = 4,
  parameter logic [NUM_DATA*8-1:0] CFG_INIT = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_DATA*8-1:0] cfg_o
);
  for (genvar i = 0; i < NUM_DATA; i++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= CFG_INIT[8*i +: 8];
      else if (wr_en_i && wr_idx_i == IDX_W'(i)) byte_q <= wr_data_i;
    end
    assign cfg_o[8*i +: 8] = byte_q;
  end
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter logic [7:0] SLAVE_ADDR = 8'hD2,
  parameter int NUM_DATA    = 8,
  parameter int HDR_BYTES   = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_DATA*8-1:0] CFG_INIT = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_DATA*8-1:0] cfg_o,
  output logic [1:0]            ss_mode_o
);
  localparam int IDX_W = $clog2(HDR_BYTES + NUM_DATA + 2);

  logic sda_s, scl_rise, scl_fall, start, stop;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  frame_ctrl #(
    .SLAVE_ADDR(SLAVE_ADDR), .NUM_DATA(NUM_DATA),
    .HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop),
    .sda_oe_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  cfg_regs #(.NUM_DATA(NUM_DATA), .IDX_W(IDX_W), .CFG_INIT(CFG_INIT)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .cfg_o
  );

  assign ss_mode_o = cfg_o[1:0];
endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk #(
  parameter int NUM_DATA = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic [NUM_DATA*8-1:0] cfg_o
);
  logic [NUM_DATA*8-1:0] cfg_q;
  logic                  q_vld;
  logic [NUM_DATA-1:0]   chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      q_vld <= 1'b0;
    end else begin
      cfg_q <= cfg_o;
      q_vld <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_DATA; i++) begin : g_chg
    assign chg[i] = cfg_q[8*i +: 8] != cfg_o[8*i +: 8];
  end

  // R11
  ack_edge_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);
  // R4
  write_clk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> scl_i);
  // R6
  one_byte_per_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_vld |-> $countones(chg) <= 1);
  // R11
  no_write_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> !sda_oe_o);
endmodule

bind cfg_serial_rx cfg_serial_rx_chk #(.NUM_DATA(NUM_DATA)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o), .cfg_o(cfg_o)
);

// File: tb/tb_cfg_serial_rx.sv
module tb_cfg_serial_rx;
  localparam logic [63:0] INIT = 64'h0123_4567_89AB_CDEF;
  localparam int Q = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0, scl = 1'b1, sda_drv = 1'b1;
  logic sda_oe_o, sda_line;
  logic [63:0] cfg_o;
  logic [1:0] ss_mode_o;
  logic [7:0] exp_b [8];
  int errors = 0, checks = 0;

  always #2 clk_i = ~clk_i;
  assign sda_line = sda_drv & ~sda_oe_o;

  cfg_serial_rx #(.CFG_INIT(INIT)) dut (
    .clk_i, .rst_ni, .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o, .cfg_o, .ss_mode_o
  );

  task automatic wq();
    repeat (Q) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] packed_exp();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = exp_b[i];
    return v;
  endfunction

  task automatic chk_regs(input string req);
    chk(req, cfg_o, packed_exp());
    chk({req, "/R8"}, {62'd0, ss_mode_o}, {62'd0, exp_b[0][1:0]});
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(); scl = 1'b1; wq(); sda_drv = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; wq(); scl = 1'b1; wq();
    ack = sda_oe_o;
    wq(); scl = 1'b0; wq();
  endtask

  // R1 R8
  task automatic t_reset();
    for (int i = 0; i < 8; i++) exp_b[i] = INIT[8*i +: 8];
    chk_regs("R1");
    chk("R1 oe", {63'd0, sda_oe_o}, 64'd0);
  endtask

  // R2 R4 R5 R8
  task automatic t_full(input logic [7:0] cmd, input logic [7:0] cnt, input logic [7:0] seed);
    logic ack;
    bus_start();
    send_byte(8'hD2, ack); chk("R2 addr ack", {63'd0, ack}, 64'd1);
    send_byte(cmd, ack);   chk("R5 cmd ack", {63'd0, ack}, 64'd1);
    send_byte(cnt, ack);   chk("R5 cnt ack", {63'd0, ack}, 64'd1);
    for (int i = 0; i < 8; i++) begin
      exp_b[i] = seed ^ 8'(i * 37);
      send_byte(exp_b[i], ack);
      chk("R4 data ack", {63'd0, ack}, 64'd1);
    end
    bus_stop();
    chk_regs("R4/R5");
  endtask

  // R2 R3
  task automatic t_bad(input logic [7:0] addr);
    logic ack;
    bus_start();
    send_byte(addr, ack); chk("R2 no ack", {63'd0, ack}, 64'd0);
    send_byte(8'h00, ack); send_byte(8'h08, ack);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'h5A, ack);
      chk("R2 skip ack", {63'd0, ack}, 64'd0);
    end
    bus_stop();
    chk_regs("R3");
  endtask

  // R6
  task automatic t_partial();
    logic ack;
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h03, ack);
    for (int i = 0; i < 3; i++) begin
      exp_b[i] = 8'hA0 + 8'(i);
      send_byte(exp_b[i], ack);
    end
    bus_stop();
    chk_regs("R6");
  endtask

  // R10
  task automatic t_mid_stop();
    logic ack;
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h11, ack); send_byte(8'h22, ack);
    exp_b[0] = 8'h3C; send_byte(exp_b[0], ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk_regs("R10");
    chk("R10 oe idle", {63'd0, sda_oe_o}, 64'd0);
  endtask

  // R7
  task automatic t_extra();
    logic ack;
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h08, ack);
    for (int i = 0; i < 8; i++) begin
      exp_b[i] = 8'h70 + 8'(i);
      send_byte(exp_b[i], ack);
    end
    for (int i = 0; i < 2; i++) begin
      send_byte(8'hFF, ack);
      chk("R7 extra ack", {63'd0, ack}, 64'd1);
      chk_regs("R7");
    end
    bus_stop();
    chk_regs("R7");
  endtask

  // R9
  task automatic t_restart();
    logic ack;
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h44, ack);
    bus_start();
    send_byte(8'hD2, ack); chk("R9 addr ack", {63'd0, ack}, 64'd1);
    send_byte(8'hE1, ack); send_byte(8'hE2, ack);
    exp_b[0] = 8'h96; send_byte(exp_b[0], ack);
    exp_b[1] = 8'h69; send_byte(exp_b[1], ack);
    bus_stop();
    chk_regs("R9");
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    wq();
    t_reset();
    t_full(8'h00, 8'h08, 8'h5C);
    t_full(8'hFF, 8'h01, 8'hC3);
    t_bad(8'hD0);
    t_bad(8'hD3);
    t_partial();
    t_mid_stop();
    t_extra();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule